// File: doc/BRIEF.md
# Subnetwork Clock-Level Governor

This block chooses the clock frequency level of the slow (non-critical) subnetwork of a two-network on-chip fabric. The fast subnetwork always runs at the top frequency; this governor only moves the slow one. Throughout each fixed-length epoch it sums the bytes injected into each of the two subnetworks, presented as per-cycle byte increments. On the last cycle of the epoch it checks whether the slow network carried more, less or exactly its fair share of the bytes. The fair share is that network's fraction of the total channel width. When the slow network carried more than its share, its clock is stepped one level down. This lengthens its fetch latency, so fewer words count as non-critical and load shifts back toward the fast network. When it carried less, the clock is stepped one level up.

The level code selects one of seven frequencies from 500 MHz to 2 GHz in 250 MHz increments. A clock-generation block outside this one consumes the code. A busy flag covers the actuation window that follows every level change. Epoch length and actuation time are cycle counts given as parameters.

Top module: `subnet_dvfs_gov`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `level` is 3 (1.25 GHz) and `busy` is 0.
- R2: `level` code k stands for 500 + 250·k MHz; it stays within 0 to NUM_LEVELS-1 (0..6 by default).
- R3: An epoch spans EPOCH_CYC consecutive cycles, counted from the first cycle after reset. The increments of every cycle of the epoch count, including its last cycle. `level` changes only on the clock edge that ends an epoch.
- R4: If slow_bytes·FAST_W > fast_bytes·SLOW_W over the epoch (slow share above θ = SLOW_W/(SLOW_W+FAST_W)), `level` drops by one.
- R5: If slow_bytes·FAST_W < fast_bytes·SLOW_W over the epoch, `level` rises by one.
- R6: If the two products are equal, including an epoch with no traffic at all, `level` is left unchanged.
- R7: A step down at level 0 and a step up at level NUM_LEVELS-1 leave `level` unchanged.
- R8: After each edge at which `level` changes, `busy` is 1 for exactly ACT_CYC cycles and then returns to 0. `busy` does not rise on an epoch end that leaves `level` unchanged.
- R9: Byte counts are cleared at each epoch end, so traffic of one epoch has no effect on the decision of the next.
- R10: The threshold follows the SLOW_W and FAST_W parameters (40 and 88 by default, θ = 31.25%), without any division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_inc | input | INC_W | Bytes injected into the slow subnetwork this cycle |
| fast_inc | input | INC_W | Bytes injected into the fast subnetwork this cycle |
| level | output | $clog2(NUM_LEVELS) | Slow-network frequency level code |
| busy | output | 1 | High during the actuation window after a level change |

## Verification
Two functions fall in the same cycle on the last cycle of every epoch. The byte increment arriving then must join the closing epoch's comparison, and the counters must be cleared so that it does not leak into the next epoch. The bench provokes this with epochs whose only traffic is on the final cycle, each followed by a silent epoch. It judges the case by expecting a step after the first epoch and a hold after the second. A near-exhaustive sweep of constant per-cycle rates also drives the level into both saturation limits. Throughout the sweep, `busy` and `level` are compared cycle by cycle against an arithmetic model.

// File: rtl/gov_pkg.sv
package gov_pkg;
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_DOWN = 2'd1,
      STEP_UP   = 2'd2
   } step_e;
endpackage

// File: rtl/gov_epoch_timer.sv
module gov_epoch_timer #(
   parameter int EPOCH_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int TW = (EPOCH_CYC > 2) ? $clog2(EPOCH_CYC) : 1;

   logic [TW-1:0] cnt_q;

   assign tick = (cnt_q == TW'(EPOCH_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/gov_traffic_acc.sv
module gov_traffic_acc #(
   parameter int INC_W = 8,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [INC_W-1:0] inc,
   output logic [CNT_W-1:0] total
);
   logic [CNT_W-1:0] acc_q;

   // running sum including this cycle's increment
   assign total = acc_q + CNT_W'(inc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc_q <= '0;
      else if (tick) acc_q <= '0;
      else           acc_q <= total;
   end
endmodule

// File: rtl/gov_share_cmp.sv
module gov_share_cmp
   import gov_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int SLOW_W = 40,
   parameter int FAST_W = 88
) (
   input  logic [CNT_W-1:0] slow_tot,
   input  logic [CNT_W-1:0] fast_tot,
   output step_e            step
);
   localparam int MAXW = (SLOW_W > FAST_W) ? SLOW_W : FAST_W;
   localparam int PW   = CNT_W + $clog2(MAXW + 1);

   logic [PW-1:0] slow_scaled;
   logic [PW-1:0] fast_scaled;

   // s/(s+f) vs S/(S+F) reduces to s*F vs f*S
   assign slow_scaled = PW'(slow_tot) * PW'(FAST_W);
   assign fast_scaled = PW'(fast_tot) * PW'(SLOW_W);

   always_comb begin
      if (slow_scaled > fast_scaled)      step = STEP_DOWN;
      else if (slow_scaled < fast_scaled) step = STEP_UP;
      else                                step = STEP_HOLD;
   end
endmodule

// File: rtl/gov_level_ctrl.sv
module gov_level_ctrl
   import gov_pkg::*;
#(
   parameter int NUM_LEVELS  = 7,
   parameter int RESET_LEVEL = 3,
   parameter int ACT_CYC     = 40000,
   parameter int LVL_W       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  step_e            step,
   output logic [LVL_W-1:0] level,
   output logic             busy
);
   localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_LEVELS - 1);
   localparam logic [LVL_W-1:0] RST_LVL = LVL_W'(RESET_LEVEL);

   logic [LVL_W-1:0] level_d;
   logic             changed;

   always_comb begin
      level_d = level;
      if (tick) begin
         if (step == STEP_DOWN && level != '0)         level_d = level - 1'b1;
         else if (step == STEP_UP && level != TOP_LVL) level_d = level + 1'b1;
      end
   end

   assign changed = (level_d != level);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level <= RST_LVL;
      else        level <= level_d;
   end

   generate
      if (ACT_CYC > 0) begin : g_act
         localparam int BW = $clog2(ACT_CYC + 1);
         logic [BW-1:0] hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              hold_q <= '0;
            else if (changed)        hold_q <= BW'(ACT_CYC);
            else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
         end
         assign busy = (hold_q != '0);
      end else begin : g_no_act
         assign busy = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/subnet_dvfs_gov.sv
module subnet_dvfs_gov
   import gov_pkg::*;
#(
   parameter int INC_W       = 8,
   parameter int SLOW_W      = 40,
   parameter int FAST_W      = 88,
   parameter int EPOCH_CYC   = 20000000,
   parameter int ACT_CYC     = 40000,
   parameter int NUM_LEVELS  = 7,
   parameter int RESET_LEVEL = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [INC_W-1:0]              slow_inc,
   input  logic [INC_W-1:0]              fast_inc,
   output logic [$clog2(NUM_LEVELS)-1:0] level,
   output logic                          busy
);
   localparam int LVL_W = $clog2(NUM_LEVELS);
   localparam int CNT_W = INC_W + $clog2(EPOCH_CYC);

   generate
      if (EPOCH_CYC < 2) begin : g_bad_epoch
         $error("EPOCH_CYC must be at least 2");
      end
      if (ACT_CYC >= EPOCH_CYC) begin : g_bad_act
         $error("ACT_CYC must be shorter than EPOCH_CYC");
      end
      if (NUM_LEVELS < 2) begin : g_bad_levels
         $error("NUM_LEVELS must be at least 2");
      end
      if (RESET_LEVEL < 0 || RESET_LEVEL >= NUM_LEVELS) begin : g_bad_rst
         $error("RESET_LEVEL out of range");
      end
      if (SLOW_W < 1 || FAST_W < 1) begin : g_bad_width
         $error("channel widths must be positive");
      end
   endgenerate

   logic             epoch_tick;
   logic [INC_W-1:0] inc_lane [2];
   logic [CNT_W-1:0] tot_lane [2];
   step_e            step;

   assign inc_lane[0] = slow_inc;
   assign inc_lane[1] = fast_inc;

   gov_epoch_timer #(.EPOCH_CYC(EPOCH_CYC)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (epoch_tick)
   );

   generate
      for (genvar g = 0; g < 2; g++) begin : g_lane
         gov_traffic_acc #(.INC_W(INC_W), .CNT_W(CNT_W)) u_acc (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (epoch_tick),
            .inc  (inc_lane[g]),
            .total(tot_lane[g])
         );
      end
   endgenerate

   gov_share_cmp #(.CNT_W(CNT_W), .SLOW_W(SLOW_W), .FAST_W(FAST_W)) u_cmp (
      .slow_tot(tot_lane[0]),
      .fast_tot(tot_lane[1]),
      .step    (step)
   );

   gov_level_ctrl #(
      .NUM_LEVELS (NUM_LEVELS),
      .RESET_LEVEL(RESET_LEVEL),
      .ACT_CYC    (ACT_CYC),
      .LVL_W      (LVL_W)
   ) u_lvl (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (epoch_tick),
      .step (step),
      .level(level),
      .busy (busy)
   );
endmodule

// File: rtl/subnet_dvfs_gov_chk.sv
module subnet_dvfs_gov_chk #(
   parameter int NUM_LEVELS = 7,
   parameter int ACT_CYC    = 1,
   parameter int LVL_W      = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LVL_W-1:0] level,
   input logic             busy,
   input logic             epoch_tick
);
   assert_level_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      int'(level) < NUM_LEVELS);

   assert_change_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(level) |-> $past(epoch_tick));

   assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(level) |-> (level == $past(level) + 1'b1 || level + 1'b1 == $past(level)));

   assert_busy_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ACT_CYC > 0) && !$stable(level) |-> busy);

   assert_busy_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$stable(level));
endmodule

bind subnet_dvfs_gov subnet_dvfs_gov_chk #(
   .NUM_LEVELS(NUM_LEVELS),
   .ACT_CYC   (ACT_CYC),
   .LVL_W     (LVL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .level     (level),
   .busy      (busy),
   .epoch_tick(epoch_tick)
);

// File: tb/subnet_dvfs_gov_tb.sv
`timescale 1ns/1ps
module subnet_dvfs_gov_tb;
   localparam int INC_W  = 4;
   localparam int SW     = 40;
   localparam int FW     = 88;
   localparam int EPOCH  = 16;
   localparam int ACT    = 3;
   localparam int NLVL   = 7;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [INC_W-1:0] slow_inc = '0;
   logic [INC_W-1:0] fast_inc = '0;
   logic [2:0]       level;
   logic             busy;

   int  n_chk = 0;
   int  n_bad = 0;
   int  exp_lvl = 3;
   bit  prev_chg = 1'b0;

   always #2 clk = ~clk;

   subnet_dvfs_gov #(
      .INC_W(INC_W), .SLOW_W(SW), .FAST_W(FW),
      .EPOCH_CYC(EPOCH), .ACT_CYC(ACT), .NUM_LEVELS(NLVL), .RESET_LEVEL(3)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .slow_inc(slow_inc), .fast_inc(fast_inc),
      .level(level), .busy(busy)
   );

   task automatic check(input string req, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
      end
   endtask

   // one epoch: body values for cycles 0..EPOCH-2, last values on final cycle
   task automatic run_epoch(input int sb, input int fb, input int sl, input int fl);
      int s_tot;
      int f_tot;
      s_tot = sb * (EPOCH - 1) + sl;
      f_tot = fb * (EPOCH - 1) + fl;
      for (int i = 0; i < EPOCH; i++) begin
         check("R8 busy window", int'(busy), int'(prev_chg && i < ACT));
         check("R3 level steady", int'(level), exp_lvl);
         slow_inc = INC_W'((i == EPOCH - 1) ? sl : sb);
         fast_inc = INC_W'((i == EPOCH - 1) ? fl : fb);
         @(posedge clk);
         @(negedge clk);
      end
      prev_chg = 1'b0;
      if (s_tot * FW > f_tot * SW) begin        // R4, R7 at floor
         if (exp_lvl > 0) begin exp_lvl--; prev_chg = 1'b1; end
      end else if (s_tot * FW < f_tot * SW) begin // R5, R7 at ceiling
         if (exp_lvl < NLVL - 1) begin exp_lvl++; prev_chg = 1'b1; end
      end                                       // R6 hold
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset level", int'(level), 3);
      check("R1 reset busy", int'(busy), 0);
      rst_n = 1'b1;
      // R1 first post-reset cycle checked inside the first epoch, i=0
      // R6 silent epoch holds
      run_epoch(0, 0, 0, 0);
      // R10 threshold 31.25%: slow 5 / fast 11 is exactly on it (5*88 == 11*40)
      run_epoch(5, 11, 5, 11);
      run_epoch(6, 11, 6, 11);   // R4 above
      run_epoch(5, 12, 5, 12);   // R5 below
      // R3 R9: traffic only on the final cycle counts, then cleared
      run_epoch(0, 0, 9, 0);     // down
      run_epoch(0, 0, 0, 0);     // hold
      run_epoch(0, 0, 0, 7);     // up
      run_epoch(0, 0, 0, 0);     // hold
      run_epoch(15, 0, 15, 0);   // R9 heavy slow epoch
      run_epoch(0, 0, 0, 0);     // must hold
      // near-exhaustive sweep of constant per-cycle rates; saturates R7
      for (int s = 0; s < 16; s++)
         for (int f = 0; f < 16; f++)
            run_epoch(s, f, s, f);
      // R7 explicit ceiling and floor
      for (int k = 0; k < 8; k++) run_epoch(0, 9, 0, 9);
      check("R7 ceiling", int'(level), NLVL - 1);
      for (int k = 0; k < 8; k++) run_epoch(9, 0, 9, 0);
      check("R7 floor", int'(level), 0);
      run_epoch(0, 0, 0, 0);
      check("R2 level code", int'(level), exp_lvl);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule